// File: doc/BRIEF.md
# Local-History Branch Target Predictor

This block predicts branch direction and target in the fetch stage. A direct-mapped, tagged target buffer holds one record per index: a valid flag, an address tag, the branch target, a short history shift register of that branch's own past outcomes, and a private table of 2-bit saturating counters that the history selects. A lookup that hits returns the stored target and the direction read from the selected counter, and it also returns the history value used (a checkpoint) so that the fetch pipeline can hand it back when the branch resolves.

On a lookup hit the entry's history is advanced at once with the predicted outcome. When the branch resolves, the counter picked by the returned checkpoint is trained with the real outcome, and on a misprediction the history is rebuilt from the checkpoint with the real outcome appended. A lookup that misses the buffer gets a fixed static decision from decoded branch attributes: only a conditional PC-relative branch whose target lies forward is predicted not taken. Entries are created only by taken branches that resolve without a matching entry.

Top module: `lhb_predictor`

## Requirements
- R1: With `lkp_valid_i` low, `pred_hit_o` and `pred_taken_o` are 0; after reset every lookup misses.
- R2: The index is `pc[ALN_W +: IDX_W]` and the tag is the remaining upper PC bits; a lookup hits only when the indexed entry is valid and its tag matches, and then `pred_target_o` is the stored target. Two PCs with the same index and different tags do not share a hit.
- R3: On a hit, `pred_taken_o` is bit 1 of the entry's counter selected by the entry's history, and `pred_ckpt_o` is that history value.
- R4: A hit shifts the entry's history left by one, with the predicted direction entering bit 0 and the oldest bit dropping out.
- R5: On a miss (`lkp_valid_i` high), `pred_hit_o` is 0, `pred_target_o` and `pred_ckpt_o` are 0, and `pred_taken_o` is 0 only when `lkp_cond_i`=1, `lkp_pcrel_i`=1 and `lkp_back_i`=0; otherwise (unconditional, return, indirect, backward conditional) it is 1.
- R6: A resolve that hits trains the entry's counter selected by `res_ckpt_i`: +1 on taken, -1 on not taken, held within 0..3.
- R7: A resolve hit with `res_mispred_i`=1 sets the entry's history to `{res_ckpt_i[HIST_W-2:0], res_taken_i}`; without it the resolve leaves the history unchanged.
- R8: A taken resolve that misses writes that index: valid, tag and target from the resolve, history 0, all counters 2. A not-taken resolve that misses changes nothing.
- R9: When a lookup hit and a resolve address the same index in one cycle, the speculative history shift is dropped and only the resolve acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_pc_i | input | PC_W | Lookup branch address |
| lkp_cond_i | input | 1 | Branch is conditional |
| lkp_pcrel_i | input | 1 | Branch target is PC-relative |
| lkp_back_i | input | 1 | PC-relative target is backward |
| pred_hit_o | output | 1 | Buffer hit |
| pred_taken_o | output | 1 | Predicted direction |
| pred_target_o | output | PC_W | Predicted target (0 on miss) |
| pred_ckpt_o | output | HIST_W | History checkpoint used for the prediction |
| res_valid_i | input | 1 | Resolve request |
| res_pc_i | input | PC_W | Resolved branch address |
| res_taken_i | input | 1 | Actual direction |
| res_mispred_i | input | 1 | Prediction was wrong |
| res_ckpt_i | input | HIST_W | Checkpoint returned from the lookup |
| res_target_i | input | PC_W | Actual target, stored on allocation |

## Verification
The bench builds the block with 8 entries, a 3-bit history and a 12-bit PC, so the whole index space, several tags per index and all eight counters of an entry are reached within a few cycles. Directed sequences drive one entry through allocation, counter saturation at both ends, checkpoint restore and same-index collisions, and all eight static attribute combinations are swept. A long random run over a 64-address window then compares every output each cycle against an arithmetic model of the buffer kept in the bench.

// File: rtl/lhb_pkg.sv
package lhb_pkg;
  localparam logic [1:0] CTR_INIT = 2'b10;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/lhb_static_rule.sv
module lhb_static_rule (
  input  logic cond_i,
  input  logic pcrel_i,
  input  logic back_i,
  output logic taken_o
);
  // only a forward conditional relative branch falls through
  always_comb taken_o = ~(cond_i & pcrel_i & ~back_i);
endmodule

// File: rtl/lhb_ctr_read.sv
module lhb_ctr_read #(
  parameter int HIST_W = 4,
  localparam int NCTR = 1 << HIST_W
) (
  input  logic [2*NCTR-1:0] tbl_i,
  input  logic [HIST_W-1:0] sel_i,
  output logic [1:0]        ctr_o
);
  logic [1:0] ctr_arr [NCTR];
  for (genvar g = 0; g < NCTR; g++) begin : g_slot
    assign ctr_arr[g] = tbl_i[2*g +: 2];
  end
  assign ctr_o = ctr_arr[sel_i];
endmodule

// File: rtl/lhb_ctr_train.sv
module lhb_ctr_train
  import lhb_pkg::*;
#(
  parameter int HIST_W = 4,
  localparam int NCTR = 1 << HIST_W
) (
  input  logic [2*NCTR-1:0] tbl_i,
  input  logic [HIST_W-1:0] sel_i,
  input  logic              up_i,
  output logic [2*NCTR-1:0] tbl_o
);
  for (genvar g = 0; g < NCTR; g++) begin : g_slot
    assign tbl_o[2*g +: 2] = (sel_i == HIST_W'(g)) ? ctr_step(tbl_i[2*g +: 2], up_i)
                                                   : tbl_i[2*g +: 2];
  end
endmodule

// File: rtl/lhb_store.sv
module lhb_store #(
  parameter int ENTRIES  = 512,
  parameter int IDX_W    = 9,
  parameter int TAG_W    = 21,
  parameter int PC_W     = 32,
  parameter int HIST_W   = 4,
  parameter int CTR_BITS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  // port a: lookup side
  input  logic [IDX_W-1:0]    a_idx_i,
  output logic                a_valid_o,
  output logic [TAG_W-1:0]    a_tag_o,
  output logic [PC_W-1:0]     a_tgt_o,
  output logic [HIST_W-1:0]   a_hist_o,
  output logic [CTR_BITS-1:0] a_ctr_o,
  input  logic                a_hist_we_i,
  input  logic [HIST_W-1:0]   a_hist_i,
  // port b: resolve side
  input  logic [IDX_W-1:0]    b_idx_i,
  output logic                b_valid_o,
  output logic [TAG_W-1:0]    b_tag_o,
  output logic [CTR_BITS-1:0] b_ctr_o,
  input  logic                b_hist_we_i,
  input  logic [HIST_W-1:0]   b_hist_i,
  input  logic                b_ctr_we_i,
  input  logic [CTR_BITS-1:0] b_ctr_i,
  input  logic                b_alloc_i,
  input  logic [TAG_W-1:0]    b_tag_i,
  input  logic [PC_W-1:0]     b_tgt_i
);
  logic                valid_q [ENTRIES];
  logic [TAG_W-1:0]    tag_q   [ENTRIES];
  logic [PC_W-1:0]     tgt_q   [ENTRIES];
  logic [HIST_W-1:0]   hist_q  [ENTRIES];
  logic [CTR_BITS-1:0] ctr_q   [ENTRIES];

  assign a_valid_o = valid_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_tgt_o   = tgt_q[a_idx_i];
  assign a_hist_o  = hist_q[a_idx_i];
  assign a_ctr_o   = ctr_q[a_idx_i];
  assign b_valid_o = valid_q[b_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_ctr_o   = ctr_q[b_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
    end else if (b_alloc_i) begin
      valid_q[b_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (b_alloc_i) begin
      tag_q[b_idx_i] <= b_tag_i;
      tgt_q[b_idx_i] <= b_tgt_i;
    end
    if (b_ctr_we_i) ctr_q[b_idx_i] <= b_ctr_i;
    if (a_hist_we_i) hist_q[a_idx_i] <= a_hist_i;
    // resolve write last: wins on equal index
    if (b_hist_we_i) hist_q[b_idx_i] <= b_hist_i;
  end
endmodule

// File: rtl/lhb_predictor.sv
module lhb_predictor
  import lhb_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int HIST_W  = 4,
  parameter int PC_W    = 32,
  parameter int ALN_W   = 2,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int TAG_W    = PC_W - IDX_W - ALN_W,
  localparam int CTR_BITS = 2 << HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [PC_W-1:0]   lkp_pc_i,
  input  logic              lkp_cond_i,
  input  logic              lkp_pcrel_i,
  input  logic              lkp_back_i,
  output logic              pred_hit_o,
  output logic              pred_taken_o,
  output logic [PC_W-1:0]   pred_target_o,
  output logic [HIST_W-1:0] pred_ckpt_o,
  input  logic              res_valid_i,
  input  logic [PC_W-1:0]   res_pc_i,
  input  logic              res_taken_i,
  input  logic              res_mispred_i,
  input  logic [HIST_W-1:0] res_ckpt_i,
  input  logic [PC_W-1:0]   res_target_i
);
  logic [IDX_W-1:0]    lk_idx, rs_idx;
  logic [TAG_W-1:0]    lk_tag, rs_tag;
  logic                lk_valid, rs_valid;
  logic [TAG_W-1:0]    lk_tag_q, rs_tag_q;
  logic [PC_W-1:0]     lk_tgt;
  logic [HIST_W-1:0]   lk_hist;
  logic [CTR_BITS-1:0] lk_ctr, rs_ctr, rs_ctr_trained, rs_ctr_wr;
  logic [1:0]          lk_sel_ctr;
  logic                lk_hit, dyn_taken, stat_taken;
  logic                res_hit, same_idx, spec_we, alloc, res_hist_we;
  logic [HIST_W-1:0]   spec_hist, res_hist;

  assign lk_idx = lkp_pc_i[ALN_W +: IDX_W];
  assign lk_tag = lkp_pc_i[PC_W-1 -: TAG_W];
  assign rs_idx = res_pc_i[ALN_W +: IDX_W];
  assign rs_tag = res_pc_i[PC_W-1 -: TAG_W];

  lhb_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W),
    .HIST_W(HIST_W), .CTR_BITS(CTR_BITS)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_idx_i     (lk_idx),
    .a_valid_o   (lk_valid),
    .a_tag_o     (lk_tag_q),
    .a_tgt_o     (lk_tgt),
    .a_hist_o    (lk_hist),
    .a_ctr_o     (lk_ctr),
    .a_hist_we_i (spec_we),
    .a_hist_i    (spec_hist),
    .b_idx_i     (rs_idx),
    .b_valid_o   (rs_valid),
    .b_tag_o     (rs_tag_q),
    .b_ctr_o     (rs_ctr),
    .b_hist_we_i (res_hist_we),
    .b_hist_i    (res_hist),
    .b_ctr_we_i  (alloc | res_hit),
    .b_ctr_i     (rs_ctr_wr),
    .b_alloc_i   (alloc),
    .b_tag_i     (rs_tag),
    .b_tgt_i     (res_target_i)
  );

  lhb_ctr_read #(.HIST_W(HIST_W)) u_rd (
    .tbl_i (lk_ctr),
    .sel_i (lk_hist),
    .ctr_o (lk_sel_ctr)
  );

  lhb_ctr_train #(.HIST_W(HIST_W)) u_trn (
    .tbl_i (rs_ctr),
    .sel_i (res_ckpt_i),
    .up_i  (res_taken_i),
    .tbl_o (rs_ctr_trained)
  );

  lhb_static_rule u_stat (
    .cond_i  (lkp_cond_i),
    .pcrel_i (lkp_pcrel_i),
    .back_i  (lkp_back_i),
    .taken_o (stat_taken)
  );

  // lookup side
  assign lk_hit    = lkp_valid_i & lk_valid & (lk_tag_q == lk_tag);
  assign dyn_taken = lk_sel_ctr[1];
  assign spec_hist = {lk_hist[HIST_W-2:0], dyn_taken};
  assign same_idx  = res_valid_i & (rs_idx == lk_idx);
  assign spec_we   = lk_hit & ~same_idx;

  assign pred_hit_o    = lk_hit;
  assign pred_taken_o  = lkp_valid_i & (lk_hit ? dyn_taken : stat_taken);
  assign pred_target_o = lk_hit ? lk_tgt : '0;
  assign pred_ckpt_o   = lk_hit ? lk_hist : '0;

  // resolve side
  assign res_hit     = res_valid_i & rs_valid & (rs_tag_q == rs_tag);
  assign alloc       = res_valid_i & ~res_hit & res_taken_i;
  assign res_hist_we = alloc | (res_hit & res_mispred_i);
  assign res_hist    = alloc ? '0 : {res_ckpt_i[HIST_W-2:0], res_taken_i};
  assign rs_ctr_wr   = alloc ? {(1 << HIST_W){CTR_INIT}} : rs_ctr_trained;
endmodule

// File: rtl/lhb_predictor_chk.sv
module lhb_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lkp_valid_i,
  input logic [PC_W-1:0]   lkp_pc_i,
  input logic              lkp_pcrel_i,
  input logic              pred_hit_o,
  input logic              pred_taken_o,
  input logic [PC_W-1:0]   pred_target_o,
  input logic [HIST_W-1:0] pred_ckpt_o,
  input logic              res_valid_i,
  input logic [PC_W-1:0]   res_pc_i,
  input logic              res_taken_i,
  input logic              res_mispred_i,
  input logic [HIST_W-1:0] res_ckpt_i,
  input logic [PC_W-1:0]   res_target_i,
  input logic              res_hit
);
  logic [HIST_W-1:0] push_now, restore_now;
  assign push_now    = {pred_ckpt_o[HIST_W-2:0], pred_taken_o};
  assign restore_now = {res_ckpt_i[HIST_W-2:0], res_taken_i};

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> (!pred_hit_o && !pred_taken_o));

  a_r5_nonrel_miss_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !pred_hit_o && !lkp_pcrel_i) |-> (pred_taken_o && pred_target_o == '0));

  a_r4_spec_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lkp_valid_i && pred_hit_o && !res_valid_i) && lkp_valid_i && pred_hit_o
     && lkp_pc_i == $past(lkp_pc_i)) |-> pred_ckpt_o == $past(push_now));

  a_r7_mispred_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_hit && res_mispred_i) && lkp_valid_i && lkp_pc_i == $past(res_pc_i))
    |-> (pred_hit_o && pred_ckpt_o == $past(restore_now)));

  a_r8_alloc_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_valid_i && res_taken_i && !res_hit) && lkp_valid_i && lkp_pc_i == $past(res_pc_i))
    |-> (pred_hit_o && pred_taken_o && pred_ckpt_o == '0 && pred_target_o == $past(res_target_i)));

  a_r8_nt_miss_noalloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_valid_i && !res_taken_i && !res_hit) && lkp_valid_i && lkp_pc_i == $past(res_pc_i))
    |-> !pred_hit_o);
endmodule

bind lhb_predictor lhb_predictor_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lkp_valid_i   (lkp_valid_i),
  .lkp_pc_i      (lkp_pc_i),
  .lkp_pcrel_i   (lkp_pcrel_i),
  .pred_hit_o    (pred_hit_o),
  .pred_taken_o  (pred_taken_o),
  .pred_target_o (pred_target_o),
  .pred_ckpt_o   (pred_ckpt_o),
  .res_valid_i   (res_valid_i),
  .res_pc_i      (res_pc_i),
  .res_taken_i   (res_taken_i),
  .res_mispred_i (res_mispred_i),
  .res_ckpt_i    (res_ckpt_i),
  .res_target_i  (res_target_i),
  .res_hit       (res_hit)
);

// File: tb/lhb_predictor_tb_top.sv
module lhb_predictor_tb_top;
  localparam int E  = 8;
  localparam int H  = 3;
  localparam int PW = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lkp_valid_i = 0, lkp_cond_i = 0, lkp_pcrel_i = 0, lkp_back_i = 0;
  logic [PW-1:0] lkp_pc_i = '0;
  logic pred_hit_o, pred_taken_o;
  logic [PW-1:0] pred_target_o;
  logic [H-1:0] pred_ckpt_o;
  logic res_valid_i = 0, res_taken_i = 0, res_mispred_i = 0;
  logic [PW-1:0] res_pc_i = '0, res_target_i = '0;
  logic [H-1:0] res_ckpt_i = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lhb_predictor #(.ENTRIES(E), .HIST_W(H), .PC_W(PW), .ALN_W(1)) dut_i (.*);

  // reference model
  bit            m_v   [E];
  logic [7:0]    m_tag [E];
  logic [PW-1:0] m_tgt [E];
  logic [H-1:0]  m_h   [E];
  logic [1:0]    m_c   [E][1<<H];

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic step(string req, bit lv, logic [PW-1:0] lpc, bit lc, bit lp, bit lb,
                      bit rv, logic [PW-1:0] rpc, bit rt, bit rm, logic [H-1:0] rck,
                      logic [PW-1:0] rtg);
    int li, ri;
    bit eh, et, rh;
    logic [PW-1:0] etg;
    logic [H-1:0] eck;
    string lab;
    @(negedge clk_i);
    lkp_valid_i = lv; lkp_pc_i = lpc; lkp_cond_i = lc; lkp_pcrel_i = lp; lkp_back_i = lb;
    res_valid_i = rv; res_pc_i = rpc; res_taken_i = rt; res_mispred_i = rm;
    res_ckpt_i = rck; res_target_i = rtg;
    li = int'(lpc[3:1]);
    ri = int'(rpc[3:1]);
    eh  = lv && m_v[li] && m_tag[li] == lpc[11:4];
    et  = lv && (eh ? m_c[li][m_h[li]][1] : !(lc && lp && !lb));
    etg = eh ? m_tgt[li] : '0;
    eck = eh ? m_h[li] : '0;
    #1;
    lab = req;
    if (lab == "") lab = !lv ? "R1" : (eh ? "R3" : "R5");
    chk(lab, {15'd0, pred_hit_o, pred_taken_o, pred_target_o, pred_ckpt_o},
             {15'd0, eh, et, etg, eck});
    // model update from pre-edge state
    rh = rv && m_v[ri] && m_tag[ri] == rpc[11:4];
    if (eh && !(rv && ri == li)) m_h[li] = {m_h[li][H-2:0], et};
    if (rh) begin
      if (rt) m_c[ri][rck] = (m_c[ri][rck] == 2'd3) ? 2'd3 : m_c[ri][rck] + 2'd1;
      else    m_c[ri][rck] = (m_c[ri][rck] == 2'd0) ? 2'd0 : m_c[ri][rck] - 2'd1;
      if (rm) m_h[ri] = {rck[H-2:0], rt};
    end else if (rv && rt) begin
      m_v[ri] = 1; m_tag[ri] = rpc[11:4]; m_tgt[ri] = rtg; m_h[ri] = '0;
      for (int k = 0; k < (1 << H); k++) m_c[ri][k] = 2'd2;
    end
    @(posedge clk_i);
  endtask

  task automatic look(string req, logic [PW-1:0] pc);
    step(req, 1, pc, 1, 1, 0, 0, '0, 0, 0, '0, '0);
  endtask

  task automatic resolve(string req, logic [PW-1:0] pc, bit t, bit m, logic [H-1:0] ck,
                         logic [PW-1:0] tg);
    step(req, 0, '0, 0, 0, 0, 1, pc, t, m, ck, tg);
  endtask

  localparam logic [PW-1:0] PA = 12'h012;  // idx 1, tag 1
  localparam logic [PW-1:0] PB = 12'h022;  // idx 1, tag 2
  localparam logic [PW-1:0] PC = 12'h006;  // idx 3

  initial begin
    for (int i = 0; i < E; i++) m_v[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset leaves all entries empty, idle is quiet
    for (int p = 0; p < 64; p++) look("R1", PW'(p));
    step("R1", 0, PA, 1, 1, 1, 0, '0, 0, 0, '0, '0);
    // R5: all attribute combinations on a miss
    for (int a = 0; a < 8; a++) step("R5", 1, PA, a[2], a[1], a[0], 0, '0, 0, 0, '0, '0);
    // R8: allocate and see it
    resolve("R8", PA, 1, 0, 3'd0, 12'hABC);
    look("R8", PA);
    // R2: alias at same index, other tag
    look("R2", PB);
    // R6: drive counter 0 to the floor
    repeat (3) resolve("R6", PA, 0, 0, 3'd0, '0);
    resolve("R7", PA, 0, 1, 3'd0, '0);
    look("R6", PA);
    look("R4", PA);
    repeat (4) resolve("R6", PA, 1, 0, 3'd0, '0);
    look("R6", PA);
    look("R4", PA);
    // R7: restore and plain resolve
    resolve("R7", PA, 0, 1, 3'd5, '0);
    look("R7", PA);
    resolve("R7", PA, 1, 0, 3'd0, '0);
    look("R7", PA);
    // R9: collision on one index
    step("R9", 1, PA, 1, 1, 0, 1, PA, 1, 0, 3'd0, '0);
    look("R9", PA);
    step("R9", 1, PA, 1, 1, 0, 1, PB, 1, 0, 3'd0, 12'h5A5);
    look("R9", PB);
    // R8: not-taken miss leaves nothing
    resolve("R8", PC, 0, 0, 3'd0, 12'h111);
    look("R8", PC);
    // random sweep over a 64-address window
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("", r[1:0] != 0, PW'($urandom & 32'h3F), r[2], r[3], r[4],
           r[5], PW'($urandom & 32'h3F), r[6], r[7], r[10:8], PW'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule